// File: doc/BRIEF.md
# Vectored Interrupt Controller for 64 Level Sources

This block gathers 64 level-sensitive interrupt lines and steers each one, by a per-source type bit, onto one of two request paths: a normal path and a fast path. For each path it picks a single winner among the sources that are pending there. The winner is the source with the highest 4-bit priority, and on a priority tie the higher source number wins. Firmware reads the winner's number and priority from a per-path vector register. A request output per path tells the processor that something is waiting. The normal output is further gated by a programmable priority threshold.

Firmware drives the block over a simple register bus with a byte address, 32-bit write data, and write and read strobes. Every per-source bitmap is split across two 32-bit words: a low word for sources 0 to 31 and a high word for sources 32 to 63. Enables can be changed as whole words, or one source at a time by writing that source's number to a set-by-number or clear-by-number register. A software force word can raise any source. A separate pair of wake-mask words drives a 64-bit output to the power controller, with inverted polarity.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, all enable, type, force and priority bits are 0, the control word reads 0, the normal threshold (0x04) reads 0x1F, both wake words read 0xFFFFFFFF, both vector registers read 0xFFFF0000, and both request outputs are low.
- R2: Each per-source bitmap stores source i in bit i of its low word when i < 32, and in bit i−32 of its high word otherwise. The pairs are enable 0x10/0x14, type 0x18/0x1C, raw input 0x48/0x4C, force 0x50/0x54, normal pending 0x58/0x5C and fast pending 0x60/0x64, each written high/low. Writable words read back as written.
- R3: A source is active when (raw input OR force bit) AND its enable bit is set. An active source with type bit 1 is pending on the fast path only, and one with type bit 0 is pending on the normal path only. The pending words show exactly this.
- R4: The normal vector (0x40) and the fast vector (0x44) return the winning source number in bits 31:16 and its priority in bits 3:0, with bits 15:4 zero. The winner has the highest priority, and on a tie the highest source number wins. With nothing pending, the register reads 0xFFFF0000.
- R5: The fast request output is high exactly one clock after a clock in which some source is pending on the fast path. It is never gated by the threshold.
- R6: A write to 0x08 sets, and a write to 0x0C clears, only the enable bit of the source numbered by write data bits 5:0. Higher data bits are ignored. Both registers read 0.
- R7: The normal threshold is a 5-bit field. The normal request output is high one clock after a normal winner exists and either threshold bit 4 is 1 or the winner's priority is strictly greater than threshold bits 3:0. The vector register shows the winner whatever the threshold is.
- R8: Priority register k (k = 0..7) sits at byte address 0x20 + 4·(7−k). Its bits 4j+3:4j hold the priority of source 8k+j.
- R9: The wake words 0x68 (sources 0–31) and 0x6C (sources 32–63) drive the wake-mask output bit for bit, where 0 lets a source wake the system. They change only when written.
- R10: Register writes take effect at the write clock edge. Read data is registered: it appears at the clock edge where the read strobe is sampled and holds until the next read. The raw-input words return the source pins as sampled at that edge.
- R11: The control word (0x00) stores all 32 written bits and reads them back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Registered read data |
| irq_src | input | 64 | Level interrupt inputs, bit i is source i |
| irq_normal | output | 1 | Normal-path request |
| irq_fast | output | 1 | Fast-path request |
| wake_mask | output | 64 | Low-power wake mask, 0 allows a source to wake |

## Verification
The bench builds the block with its default parameters: 64 sources, 4-bit priorities and arbitration groups of eight. With these values a tie can fall inside one group or across groups. Both halves of every bitmap are reachable, and the threshold can take every priority value as well as its disabling value. Directed sequences cover the tie rule, a winner that lies exactly at the threshold, and an index written with stray upper bits. Seeded sweeps then load all eight priority words with mixed type, force and input patterns. Every vector word and both request pins are compared against a model of the requirements.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

    localparam int NUM_SRC        = 64;
    localparam int WORD_W         = 32;
    localparam int HALF_SRC       = NUM_SRC / 2;
    localparam int PRIO_W         = 4;
    localparam int NMASK_W        = PRIO_W + 1;
    localparam int ADDR_W         = 8;
    localparam int IDX_W          = $clog2(NUM_SRC);
    localparam int FIELDS_PER_REG = WORD_W / PRIO_W;
    localparam int PRIO_REGS      = NUM_SRC / FIELDS_PER_REG;
    localparam int NUM_PATHS      = 2;
    localparam int PATH_NORMAL    = 0;
    localparam int PATH_FAST      = 1;

    localparam logic [ADDR_W-1:0] OFF_CTRL     = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_NMASK    = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_EN_NUM   = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_DIS_NUM  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFF_EN_H     = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_EN_L     = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_TYP_H    = 8'h18;
    localparam logic [ADDR_W-1:0] OFF_TYP_L    = 8'h1C;
    localparam logic [ADDR_W-1:0] OFF_PRIO_LO  = 8'h20;
    localparam logic [ADDR_W-1:0] OFF_NVEC     = 8'h40;
    localparam logic [ADDR_W-1:0] OFF_FVEC     = 8'h44;
    localparam logic [ADDR_W-1:0] OFF_RAW_H    = 8'h48;
    localparam logic [ADDR_W-1:0] OFF_RAW_L    = 8'h4C;
    localparam logic [ADDR_W-1:0] OFF_FRC_H    = 8'h50;
    localparam logic [ADDR_W-1:0] OFF_FRC_L    = 8'h54;
    localparam logic [ADDR_W-1:0] OFF_NPND_H   = 8'h58;
    localparam logic [ADDR_W-1:0] OFF_NPND_L   = 8'h5C;
    localparam logic [ADDR_W-1:0] OFF_FPND_H   = 8'h60;
    localparam logic [ADDR_W-1:0] OFF_FPND_L   = 8'h64;
    localparam logic [ADDR_W-1:0] OFF_WAKE_L   = 8'h68;
    localparam logic [ADDR_W-1:0] OFF_WAKE_H   = 8'h6C;

    // Programmable configuration held by the register file.
    typedef struct packed {
        logic [WORD_W-1:0]          ctrl;
        logic [NMASK_W-1:0]         nmask;
        logic [NUM_SRC-1:0]         en;
        logic [NUM_SRC-1:0]         typ;
        logic [NUM_SRC-1:0]         frc;
        logic [NUM_SRC-1:0]         wake;
        logic [NUM_SRC*PRIO_W-1:0]  prio;
    } cfg_t;

    // Registered outputs of the top level.
    typedef struct packed {
        logic [WORD_W-1:0] rdata;
        logic              nirq;
        logic              firq;
    } out_t;

    // Priority register k lives at the lowest address when k is largest.
    function automatic logic [ADDR_W-1:0] prio_addr(input int k);
        return OFF_PRIO_LO + ADDR_W'(4 * (PRIO_REGS - 1 - k));
    endfunction

    // Vector word: number in the upper half, priority in the low bits.
    function automatic logic [WORD_W-1:0] pack_vec(input logic              v,
                                                   input logic [IDX_W-1:0]  ix,
                                                   input logic [PRIO_W-1:0] pr);
        logic [WORD_W-1:0] w;
        w = '0;
        if (!v) begin
            w[WORD_W-1:WORD_W/2] = '1;
        end else begin
            w[WORD_W/2 +: IDX_W] = ix;
            w[PRIO_W-1:0]        = pr;
        end
        return w;
    endfunction

endpackage

// File: rtl/ivc_regs.sv
module ivc_regs
    import ivc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output cfg_t              cfg_o
);

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            case (addr)
                OFF_CTRL:    cfg_d.ctrl                       = wdata;
                OFF_NMASK:   cfg_d.nmask                      = wdata[NMASK_W-1:0];
                OFF_EN_NUM:  cfg_d.en[wdata[IDX_W-1:0]]       = 1'b1;
                OFF_DIS_NUM: cfg_d.en[wdata[IDX_W-1:0]]       = 1'b0;
                OFF_EN_H:    cfg_d.en[NUM_SRC-1:HALF_SRC]     = wdata;
                OFF_EN_L:    cfg_d.en[HALF_SRC-1:0]           = wdata;
                OFF_TYP_H:   cfg_d.typ[NUM_SRC-1:HALF_SRC]    = wdata;
                OFF_TYP_L:   cfg_d.typ[HALF_SRC-1:0]          = wdata;
                OFF_FRC_H:   cfg_d.frc[NUM_SRC-1:HALF_SRC]    = wdata;
                OFF_FRC_L:   cfg_d.frc[HALF_SRC-1:0]          = wdata;
                OFF_WAKE_H:  cfg_d.wake[NUM_SRC-1:HALF_SRC]   = wdata;
                OFF_WAKE_L:  cfg_d.wake[HALF_SRC-1:0]         = wdata;
                default: ;
            endcase
            for (int k = 0; k < PRIO_REGS; k++) begin
                if (addr == prio_addr(k)) begin
                    cfg_d.prio[k*WORD_W +: WORD_W] = wdata;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q       <= '0;
            cfg_q.nmask <= '1;
            cfg_q.wake  <= '1;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_o = cfg_q;

    // R6: set-by-number touches exactly the addressed enable bit
    a_r6_set_by_number: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFF_EN_NUM) |=>
            (cfg_q.en[$past(wdata[IDX_W-1:0])] &&
             $countones(cfg_q.en ^ $past(cfg_q.en)) <= 1));

    // R6: clear-by-number touches exactly the addressed enable bit
    a_r6_clear_by_number: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFF_DIS_NUM) |=>
            (!cfg_q.en[$past(wdata[IDX_W-1:0])] &&
             $countones(cfg_q.en ^ $past(cfg_q.en)) <= 1));

    // R9: wake words change only when written
    a_r9_wake_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (addr == OFF_WAKE_L || addr == OFF_WAKE_H)) |=> $stable(cfg_q.wake));

endmodule

// File: rtl/ivc_arbiter.sv
module ivc_arbiter
    import ivc_pkg::*;
#(
    parameter int N   = NUM_SRC,
    parameter int PW  = PRIO_W,
    parameter int GRP = 8
) (
    input  logic [N-1:0]             pend_i,
    input  logic [N*PW-1:0]          prio_i,
    output logic                     valid_o,
    output logic [$clog2(N)-1:0]     idx_o,
    output logic [PW-1:0]            prio_o
);

    localparam int IW = $clog2(N);
    localparam int NG = N / GRP;

    logic [NG-1:0] g_valid;
    logic [IW-1:0] g_idx  [NG];
    logic [PW-1:0] g_prio [NG];

    // First level: each group scans its members upward; >= lets the
    // higher number take a tie.
    for (genvar g = 0; g < NG; g++) begin : g_group
        logic          v;
        logic [IW-1:0] ix;
        logic [PW-1:0] pr;
        always_comb begin
            v  = 1'b0;
            ix = '0;
            pr = '0;
            for (int j = 0; j < GRP; j++) begin
                if (pend_i[g*GRP+j] && prio_i[(g*GRP+j)*PW +: PW] >= pr) begin
                    v  = 1'b1;
                    ix = IW'(g*GRP + j);
                    pr = prio_i[(g*GRP+j)*PW +: PW];
                end
            end
        end
        assign g_valid[g] = v;
        assign g_idx[g]   = ix;
        assign g_prio[g]  = pr;
    end

    // Second level: groups scanned upward with the same tie rule.
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        prio_o  = '0;
        for (int g = 0; g < NG; g++) begin
            if (g_valid[g] && g_prio[g] >= prio_o) begin
                valid_o = 1'b1;
                idx_o   = g_idx[g];
                prio_o  = g_prio[g];
            end
        end
    end

endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
    import ivc_pkg::*;
#(
    parameter int ARB_GROUP = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [31:0]       bus_rdata,
    input  logic [63:0]       irq_src,
    output logic              irq_normal,
    output logic              irq_fast,
    output logic [63:0]       wake_mask
);

    cfg_t               cfg;
    logic [NUM_SRC-1:0] active;
    logic [NUM_SRC-1:0] pend      [NUM_PATHS];
    logic [NUM_PATHS-1:0] win_valid;
    logic [IDX_W-1:0]   win_idx   [NUM_PATHS];
    logic [PRIO_W-1:0]  win_prio  [NUM_PATHS];
    logic [WORD_W-1:0]  vec_word  [NUM_PATHS];
    logic [WORD_W-1:0]  rd_word;
    out_t               st_d, st_q;

    ivc_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .cfg_o (cfg)
    );

    assign active             = (irq_src | cfg.frc) & cfg.en;
    assign pend[PATH_NORMAL]  = active & ~cfg.typ;
    assign pend[PATH_FAST]    = active &  cfg.typ;

    for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
        ivc_arbiter #(
            .N   (NUM_SRC),
            .PW  (PRIO_W),
            .GRP (ARB_GROUP)
        ) u_arb (
            .pend_i  (pend[p]),
            .prio_i  (cfg.prio),
            .valid_o (win_valid[p]),
            .idx_o   (win_idx[p]),
            .prio_o  (win_prio[p])
        );
        assign vec_word[p] = pack_vec(win_valid[p], win_idx[p], win_prio[p]);
    end

    always_comb begin
        rd_word = '0;
        case (bus_addr)
            OFF_CTRL:   rd_word = cfg.ctrl;
            OFF_NMASK:  rd_word = WORD_W'(cfg.nmask);
            OFF_EN_H:   rd_word = cfg.en[NUM_SRC-1:HALF_SRC];
            OFF_EN_L:   rd_word = cfg.en[HALF_SRC-1:0];
            OFF_TYP_H:  rd_word = cfg.typ[NUM_SRC-1:HALF_SRC];
            OFF_TYP_L:  rd_word = cfg.typ[HALF_SRC-1:0];
            OFF_NVEC:   rd_word = vec_word[PATH_NORMAL];
            OFF_FVEC:   rd_word = vec_word[PATH_FAST];
            OFF_RAW_H:  rd_word = irq_src[NUM_SRC-1:HALF_SRC];
            OFF_RAW_L:  rd_word = irq_src[HALF_SRC-1:0];
            OFF_FRC_H:  rd_word = cfg.frc[NUM_SRC-1:HALF_SRC];
            OFF_FRC_L:  rd_word = cfg.frc[HALF_SRC-1:0];
            OFF_NPND_H: rd_word = pend[PATH_NORMAL][NUM_SRC-1:HALF_SRC];
            OFF_NPND_L: rd_word = pend[PATH_NORMAL][HALF_SRC-1:0];
            OFF_FPND_H: rd_word = pend[PATH_FAST][NUM_SRC-1:HALF_SRC];
            OFF_FPND_L: rd_word = pend[PATH_FAST][HALF_SRC-1:0];
            OFF_WAKE_H: rd_word = cfg.wake[NUM_SRC-1:HALF_SRC];
            OFF_WAKE_L: rd_word = cfg.wake[HALF_SRC-1:0];
            default: ;
        endcase
        for (int k = 0; k < PRIO_REGS; k++) begin
            if (bus_addr == prio_addr(k)) begin
                rd_word = cfg.prio[k*WORD_W +: WORD_W];
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (bus_rd) begin
            st_d.rdata = rd_word;
        end
        st_d.firq = win_valid[PATH_FAST];
        st_d.nirq = win_valid[PATH_NORMAL] &&
                    (cfg.nmask[NMASK_W-1] ||
                     win_prio[PATH_NORMAL] > cfg.nmask[PRIO_W-1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata  = st_q.rdata;
    assign irq_normal = st_q.nirq;
    assign irq_fast   = st_q.firq;
    assign wake_mask  = cfg.wake;

    // R4: the normal winner is really pending on the normal path
    a_r4_normal_winner_pending: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid[PATH_NORMAL] |-> pend[PATH_NORMAL][win_idx[PATH_NORMAL]]);

    // R3: the fast winner carries a type bit of 1
    a_r3_fast_winner_typed: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid[PATH_FAST] |-> cfg.typ[win_idx[PATH_FAST]]);

    // R5: a fast request follows a cycle with a fast pending source
    a_r5_fast_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        irq_fast |-> $past(|pend[PATH_FAST]));

    // R7: a normal request follows a cycle with a normal winner
    a_r7_normal_needs_winner: assert property (@(posedge clk) disable iff (!rst_n)
        irq_normal |-> $past(win_valid[PATH_NORMAL]));

endmodule

// File: tb/vec_irq_ctrl_test.sv
module vec_irq_ctrl_test;
    import ivc_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [63:0] irq_src = '0;
    logic        irq_normal;
    logic        irq_fast;
    logic [63:0] wake_mask;

    always #2 clk = ~clk;

    vec_irq_ctrl uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_rdata  (bus_rdata),
        .irq_src    (irq_src),
        .irq_normal (irq_normal),
        .irq_fast   (irq_fast),
        .wake_mask  (wake_mask)
    );

    int n_total = 0;
    int n_fail  = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_fire = 1'b0;

    // Model of the programmed state, driven only by the requirements.
    logic [63:0] m_en = '0, m_typ = '0, m_frc = '0;
    logic [3:0]  m_prio [64];
    logic [4:0]  m_nmask = 5'h1F;

    task automatic record(input string t, input logic [63:0] act, input logic [63:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", t, act, exp);
        end
    endtask

    // Monitor: a read sampled at a rising edge is compared at the falling edge.
    always @(posedge clk) rd_fire <= bus_rd;
    always @(negedge clk) begin
        if (rd_fire) begin
            if (exp_q.size() == 0) begin
                record("R10 unexpected read", {32'h0, bus_rdata}, 64'h0);
            end else begin
                logic [31:0] e;
                string       t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                record(t, {32'h0, bus_rdata}, {32'h0, e});
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        tick();
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        bus_addr = a;
        bus_rd   = 1'b1;
        tick();
        bus_rd   = 1'b0;
    endtask

    task automatic set_prio_word(input int k, input logic [31:0] w);
        for (int j = 0; j < 8; j++) m_prio[8*k+j] = w[4*j +: 4];
        wr(8'h20 + 8'(4*(7-k)), w);
    endtask

    function automatic logic [31:0] m_vec(input bit fast);
        logic       found;
        int         bi;
        logic [3:0] bp;
        found = 1'b0;
        bi    = 0;
        bp    = '0;
        for (int i = 0; i < 64; i++) begin
            if ((irq_src[i] | m_frc[i]) && m_en[i] && (m_typ[i] == fast) && m_prio[i] >= bp) begin
                found = 1'b1;
                bi    = i;
                bp    = m_prio[i];
            end
        end
        return found ? {16'(bi), 12'h0, bp} : 32'hFFFF0000;
    endfunction

    function automatic logic m_nirq();
        logic [31:0] v;
        v = m_vec(1'b0);
        return (v[31:16] != 16'hFFFF) && (m_nmask[4] || v[3:0] > m_nmask[3:0]);
    endfunction

    function automatic logic m_firq();
        logic [31:0] v;
        v = m_vec(1'b1);
        return v[31:16] != 16'hFFFF;
    endfunction

    task automatic check_pins(input string t);
        record({t, " R7 normal pin"}, {63'h0, irq_normal}, {63'h0, m_nirq()});
        record({t, " R5 fast pin"},   {63'h0, irq_fast},   {63'h0, m_firq()});
    endtask

    initial begin
        for (int i = 0; i < 64; i++) m_prio[i] = '0;
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        record("watchdog expired", 64'h1, 64'h0);
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin : driver
        int unsigned seed;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        record("R1 normal pin", {63'h0, irq_normal}, 64'h0);
        record("R1 fast pin",   {63'h0, irq_fast},   64'h0);
        record("R1 wake pin",   wake_mask, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(8'h04, 32'h0000_001F, "R1 threshold");
        rd(8'h00, 32'h0,         "R1 control");
        rd(8'h10, 32'h0,         "R1 enable high");
        rd(8'h14, 32'h0,         "R1 enable low");
        rd(8'h1C, 32'h0,         "R1 type low");
        rd(8'h54, 32'h0,         "R1 force low");
        rd(8'h3C, 32'h0,         "R1 priority word 0");
        rd(8'h40, 32'hFFFF_0000, "R1 normal vector");
        rd(8'h44, 32'hFFFF_0000, "R1 fast vector");
        rd(8'h6C, 32'hFFFF_FFFF, "R1 wake high");

        // R11 control storage
        wr(8'h00, 32'hA5A5_0001);
        rd(8'h00, 32'hA5A5_0001, "R11 control readback");

        // R2 high word holds sources 32..63
        m_en = 64'h8000_0001_0000_0000;
        wr(8'h10, 32'h8000_0001);
        rd(8'h10, 32'h8000_0001, "R2 enable high");
        rd(8'h14, 32'h0,         "R2 enable low untouched");

        // R3: source 33 raised but disabled, source 63 enabled
        irq_src = 64'h8000_0002_0000_0000;
        rd(8'h58, 32'h8000_0000, "R3 normal pending high");
        rd(8'h48, 32'h8000_0002, "R10 raw high");
        rd(8'h4C, 32'h0,         "R10 raw low");
        rd(8'h40, 32'h003F_0000, "R4 single winner");
        tick();
        check_pins("R7 threshold disabled");

        // R8 priority layout: word 7 at 0x20 field 7 -> source 63
        set_prio_word(7, 32'h5000_0000);
        set_prio_word(4, 32'h0000_0009);
        irq_src[32] = 1'b1;
        rd(8'h2C, 32'h0000_0009, "R8 priority word 4 readback");
        rd(8'h40, 32'h0020_0009, "R4 higher priority wins");
        set_prio_word(7, 32'h9000_0000);
        rd(8'h40, 32'h003F_0009, "R4 tie goes to higher number");

        // R7 threshold at and below the winner
        m_nmask = 5'd9;
        wr(8'h04, 32'h0000_0009);
        rd(8'h04, 32'h0000_0009, "R7 threshold readback");
        tick();
        record("R7 prio equal to threshold", {63'h0, irq_normal}, 64'h0);
        rd(8'h40, 32'h003F_0009, "R7 vector ignores threshold");
        m_nmask = 5'd8;
        wr(8'h04, 32'h0000_0008);
        tick();
        record("R7 prio above threshold", {63'h0, irq_normal}, 64'h1);

        // R3 and R5: steer source 32 to the fast path
        m_typ[32] = 1'b1;
        wr(8'h18, 32'h0000_0001);
        rd(8'h44, 32'h0020_0009, "R3 fast vector");
        rd(8'h40, 32'h003F_0009, "R3 normal vector");
        rd(8'h60, 32'h0000_0001, "R3 fast pending high");
        rd(8'h58, 32'h8000_0000, "R3 normal pending high");
        tick();
        record("R5 fast pin raised", {63'h0, irq_fast}, 64'h1);

        // R6 enable by number, R3 force path
        m_frc[5] = 1'b1;
        wr(8'h54, 32'h0000_0020);
        m_en[5] = 1'b1;
        wr(8'h08, 32'h0000_0005);
        rd(8'h14, 32'h0000_0020, "R6 set by number low");
        rd(8'h10, 32'h8000_0001, "R6 other word unchanged");
        rd(8'h5C, 32'h0000_0020, "R3 forced source pending");
        rd(8'h08, 32'h0,         "R6 set register reads zero");

        // R6 clear by number with stray upper bits
        m_en[63] = 1'b0;
        wr(8'h0C, 32'h0000_00FF);
        rd(8'h10, 32'h0000_0001, "R6 clear by number ignores upper bits");
        rd(8'h40, 32'h0005_0000, "R4 remaining normal winner");
        tick();
        record("R7 prio 0 under threshold 8", {63'h0, irq_normal}, 64'h0);
        m_nmask = 5'h1F;
        wr(8'h04, 32'h0000_001F);
        tick();
        record("R7 threshold disabled again", {63'h0, irq_normal}, 64'h1);

        // Empty both paths
        m_en[5]  = 1'b0;
        m_en[32] = 1'b0;
        wr(8'h0C, 32'h0000_0005);
        wr(8'h0C, 32'h0000_0020);
        rd(8'h40, 32'hFFFF_0000, "R4 normal empty");
        rd(8'h44, 32'hFFFF_0000, "R4 fast empty");
        tick();
        record("R5 fast pin dropped",   {63'h0, irq_fast},   64'h0);
        record("R7 normal pin dropped", {63'h0, irq_normal}, 64'h0);

        // R9 wake mask
        wr(8'h68, 32'hFFFF_FFFE);
        record("R9 wake pin", wake_mask, 64'hFFFF_FFFF_FFFF_FFFE);
        rd(8'h68, 32'hFFFF_FFFE, "R9 wake low readback");
        wr(8'h00, 32'h0);
        record("R9 wake pin unchanged", wake_mask, 64'hFFFF_FFFF_FFFF_FFFE);

        // Seeded sweep of R3/R4/R5/R7
        seed = 32'h1234_5678;
        for (int it = 0; it < 12; it++) begin
            for (int k = 0; k < 8; k++) begin
                seed = seed * 32'd1664525 + 32'd1013904223;
                set_prio_word(k, seed);
            end
            seed = seed * 32'd1664525 + 32'd1013904223;
            m_en = {seed, ~seed};
            wr(8'h10, m_en[63:32]);
            wr(8'h14, m_en[31:0]);
            seed = seed * 32'd1664525 + 32'd1013904223;
            m_typ = {seed ^ 32'h0F0F_0F0F, seed};
            wr(8'h18, m_typ[63:32]);
            wr(8'h1C, m_typ[31:0]);
            seed = seed * 32'd1664525 + 32'd1013904223;
            m_frc = {32'h0, seed & 32'h0101_0101};
            wr(8'h50, 32'h0);
            wr(8'h54, m_frc[31:0]);
            seed = seed * 32'd1664525 + 32'd1013904223;
            m_nmask = (it % 3 == 0) ? 5'h1F : {1'b0, seed[7:4]};
            wr(8'h04, {27'h0, m_nmask});
            irq_src = (it % 4 == 3) ? 64'h0 : {seed, seed ^ 32'hA5A5_5A5A};
            rd(8'h40, m_vec(1'b0), "R4 sweep normal vector");
            rd(8'h44, m_vec(1'b1), "R4 sweep fast vector");
            rd(8'h5C, m_en[31:0] & ~m_typ[31:0] & (irq_src[31:0] | m_frc[31:0]),
               "R3 sweep normal pending low");
            tick();
            check_pins("sweep");
        end

        tick();
        tick();
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule